// File: doc/BRIEF.md
# Oversampling Serial Link Packet Receiver

This block receives one wire of a point-to-point serial link whose far end runs from its own clock of the same nominal frequency. There is no shared clock and no fixed phase relationship. The wire idles low, and every packet opens with a high start bit. The next bit is a type flag. When the flag is high, eight data bits follow, least significant first, and then a low stop bit. When the flag is low, the packet is an acknowledge and ends at the flag.

The receiver brings the wire through a two-flop synchroniser and watches for a rising edge while it hunts. From that edge it counts half a bit period to reach the middle of the start bit. It then samples once per bit period. The bit period comes from a 2-bit speed code, the same code the local transmitter uses.

An acknowledge packet from the far end produces a one-cycle strobe for the local transmitter. A data packet is assembled into a byte and offered to a consumer with valid/ready. The block asks the local transmitter to send an acknowledge as soon as the flag shows a data packet, before the byte has fully arrived, provided storage is free. If storage is not free, the request waits until the consumer takes the waiting byte.

The controller has six states:
- HUNT waits for a rising edge and then goes to START.
- START checks the centre of the start bit. A high sample goes to FLAG, and a low sample (a glitch) returns to HUNT.
- FLAG goes to DATA on a high sample and to HUNT on a low sample, which is an acknowledge.
- DATA shifts in eight bits and then goes to STOP.
- STOP returns to HUNT on a low sample. On a high sample it goes to DRAIN.
- DRAIN waits for the wire to go low and then returns to HUNT.

Top module: `link_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, rx_valid, ack_seen, ack_send and frame_err are all 0.
- R2: The speed code sets the bit period in clock cycles, where F is the FAST_BIT_CLKS parameter (default 4): code 0 gives 2F, code 1 gives 4F, code 2 gives 2F and code 3 gives F.
- R3: A data packet consists of a high start bit, a high flag, eight data bits sent LSB first and a low stop bit. It presents the byte on rx_data with rx_valid high, starting from the stop-bit sample.
- R4: An acknowledge packet consists of a high start bit and a low flag. It gives a one-cycle ack_seen pulse, with no byte, no ack_send and no frame_err.
- R5: When the flag of a data packet is sampled high and both storage slots are free, or the output slot is being emptied in that cycle, ack_send pulses for one cycle right after the flag sample.
- R6: If storage is not free at the flag, ack_send is withheld. It pulses in the cycle after the consumer takes the held byte. A byte that completes while the output slot is full waits in a second slot and then moves to the output. No ack_send is issued while that second slot is occupied.
- R7: While rx_valid is high and rx_ready is low, rx_valid stays high and rx_data is stable in the next cycle.
- R8: A stop bit sampled high gives a one-cycle frame_err pulse and the byte is discarded. The receiver ignores the wire until it reads low, and then decodes the next packet normally.
- R9: A high pulse on the wire that is low at the start-bit centre is dropped without any output activity, and the next real packet is received with normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input wire, asynchronous to clk |
| speed_sel | input | 2 | Speed code, latched at each start edge |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data holds a byte |
| rx_ready | input | 1 | Consumer takes the byte when high with rx_valid |
| ack_seen | output | 1 | One-cycle pulse: an acknowledge packet arrived |
| ack_send | output | 1 | One-cycle pulse: local transmitter should send an acknowledge |
| frame_err | output | 1 | One-cycle pulse: stop bit was high, byte discarded |

## Verification
Take P as the bit period and the clock edge that first captures the start bit as edge 0. The block then registers its reaction to packet bit i (start 0, flag 1, data 2 to 9, stop 10) at edge 2 + P/2 + i·P. This is two synchroniser stages plus the timer running half a period. So ack_send and ack_seen are due at edge 2 + 3P/2, while rx_valid or frame_err are due at edge 2 + P/2 + 10P. A deferred ack_send appears at the very edge where the consumer's take is registered. The bench stamps every output event with the edge count, sampling just after the falling edge, and compares the stamp against these formulas at each speed code rather than waiting loosely for the event.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_FLAG,
        ST_DATA,
        ST_STOP,
        ST_DRAIN
    } rx_state_t;

    // Clock cycles per bit for a speed code; fast is the count at the top rate.
    function automatic int bit_clks(input logic [1:0] code, input int fast);
        int r;
        unique case (code)
            2'b01:   r = 4 * fast;
            2'b11:   r = fast;
            default: r = 2 * fast;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/link_rx_sync.sv
module link_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    assign dout = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/link_rx_timer.sv
module link_rx_timer
    import link_rx_pkg::*;
#(
    parameter int FAST_BIT_CLKS = 4,
    localparam int MAX_CLKS = 4 * FAST_BIT_CLKS,
    localparam int CW = $clog2(MAX_CLKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] speed,
    output logic       tick
);
    logic [CW-1:0] per;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per <= CW'(2 * FAST_BIT_CLKS);
            cnt <= '0;
        end else if (load) begin
            per <= CW'(bit_clks(speed, FAST_BIT_CLKS));
            cnt <= CW'(bit_clks(speed, FAST_BIT_CLKS) / 2 - 1);
        end else if (cnt == '0) begin
            cnt <= per - CW'(1);
        end else begin
            cnt <= cnt - CW'(1);
        end
    end

    assign tick = (cnt == '0);
endmodule

// File: rtl/link_rx_store.sv
module link_rx_store #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_data,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              ready,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              ack_send,
    output logic              park_full
);
    logic [DATA_W-1:0] park;
    logic              owed;
    logic              take;
    logic              free;
    logic              room;

    assign take = valid & ready;
    assign free = ~valid | take;
    assign room = free & ~park_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data      <= '0;
            valid     <= 1'b0;
            park      <= '0;
            park_full <= 1'b0;
            owed      <= 1'b0;
            ack_send  <= 1'b0;
        end else begin
            ack_send <= (flag_data & room) | (owed & take);

            if (flag_data && !room) begin
                owed <= 1'b1;
            end else if (owed && take) begin
                owed <= 1'b0;
            end

            if (free) begin
                if (park_full) begin
                    data      <= park;
                    valid     <= 1'b1;
                    park_full <= byte_done;
                    if (byte_done) begin
                        park <= byte_in;
                    end
                end else if (byte_done) begin
                    data  <= byte_in;
                    valid <= 1'b1;
                end else begin
                    valid <= 1'b0;
                end
            end else if (byte_done) begin
                park      <= byte_in;
                park_full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/link_rx.sv
module link_rx
    import link_rx_pkg::*;
#(
    parameter int FAST_BIT_CLKS = 4,
    parameter int SYNC_STAGES   = 2,
    localparam int DATA_W = 8,
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic [1:0]        speed_sel,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              ack_seen,
    output logic              ack_send,
    output logic              frame_err
);
    rx_state_t         state;
    rx_state_t         state_nx;
    logic              line_s;
    logic              rise;
    logic              tick;
    logic              load;
    logic              in_pkt;
    logic              flag_data;
    logic              flag_ack;
    logic              byte_ok;
    logic              byte_bad;
    logic              shift_en;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;
    logic              park_full;

    link_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s),
        .rise (rise)
    );

    link_rx_timer #(.FAST_BIT_CLKS(FAST_BIT_CLKS)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .speed(speed_sel),
        .tick (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        load      = 1'b0;
        flag_data = 1'b0;
        flag_ack  = 1'b0;
        byte_ok   = 1'b0;
        byte_bad  = 1'b0;
        shift_en  = 1'b0;
        unique case (state)
            ST_HUNT: begin
                if (rise) begin
                    state_nx = ST_START;
                    load     = 1'b1;
                end
            end
            ST_START: begin
                if (tick) begin
                    state_nx = line_s ? ST_FLAG : ST_HUNT;
                end
            end
            ST_FLAG: begin
                if (tick) begin
                    if (line_s) begin
                        state_nx  = ST_DATA;
                        flag_data = 1'b1;
                    end else begin
                        state_nx = ST_HUNT;
                        flag_ack = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    shift_en = 1'b1;
                    if (bit_idx == IDX_W'(DATA_W - 1)) begin
                        state_nx = ST_STOP;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (line_s) begin
                        state_nx = ST_DRAIN;
                        byte_bad = 1'b1;
                    end else begin
                        state_nx = ST_HUNT;
                        byte_ok  = 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (!line_s) begin
                    state_nx = ST_HUNT;
                end
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    assign in_pkt = (state != ST_HUNT) && (state != ST_DRAIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_idx   <= '0;
            ack_seen  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            ack_seen  <= flag_ack;
            frame_err <= byte_bad;
            if (flag_data) begin
                bit_idx <= '0;
            end else if (shift_en) begin
                shreg   <= {line_s, shreg[DATA_W-1:1]};
                bit_idx <= bit_idx + IDX_W'(1);
            end
        end
    end

    link_rx_store #(.DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_data(flag_data),
        .byte_done(byte_ok),
        .byte_in  (shreg),
        .ready    (rx_ready),
        .data     (rx_data),
        .valid    (rx_valid),
        .ack_send (ack_send),
        .park_full(park_full)
    );
endmodule

// File: rtl/link_rx_chk.sv
module link_rx_chk #(
    parameter int FAST_BIT_CLKS = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] rx_data,
    input logic       ack_send,
    input logic       ack_seen,
    input logic       park_full,
    input logic       tick,
    input logic       load,
    input logic       in_pkt,
    input logic [1:0] speed_sel
);
    logic [15:0] gap;
    logic [15:0] exp_gap;
    logic [15:0] per_q;
    logic [15:0] per_now;

    always_comb begin
        case (speed_sel)
            2'b01:   per_now = 16'(4 * FAST_BIT_CLKS);
            2'b11:   per_now = 16'(FAST_BIT_CLKS);
            default: per_now = 16'(2 * FAST_BIT_CLKS);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap     <= 16'd0;
            exp_gap <= 16'd0;
            per_q   <= 16'd0;
        end else if (load) begin
            gap     <= 16'd1;
            per_q   <= per_now;
            exp_gap <= per_now / 16'd2;
        end else if (tick && in_pkt) begin
            gap     <= 16'd1;
            exp_gap <= per_q;
        end else begin
            gap <= gap + 16'd1;
        end
    end

    assert_bit_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && in_pkt) |-> (gap == exp_gap));

    assert_ack_seen_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen |=> !ack_seen);

    assert_ack_send_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_send |=> !ack_send);

    assert_no_ack_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_send |-> !park_full);

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind link_rx link_rx_chk #(.FAST_BIT_CLKS(FAST_BIT_CLKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .ack_send (ack_send),
    .ack_seen (ack_seen),
    .park_full(park_full),
    .tick     (tick),
    .load     (load),
    .in_pkt   (in_pkt),
    .speed_sel(speed_sel)
);

// File: tb/sim_link_rx.sv
module sim_link_rx;
    localparam int CLK_PERIOD = 10;
    localparam int F = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b0;
    logic [1:0] speed_sel = 2'b10;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic       ack_seen;
    logic       ack_send;
    logic       frame_err;

    int  cyc = 0;
    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;
    int  n_send = 0, n_seen = 0, n_ferr = 0, n_vrise = 0;
    int  t_send = -1, t_seen = -1, t_ferr = -1, t_vrise = -1;
    logic [7:0] d_vrise = 8'h00;
    logic pv = 1'b0;

    link_rx #(.FAST_BIT_CLKS(F)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .speed_sel(speed_sel),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .ack_seen(ack_seen), .ack_send(ack_send), .frame_err(frame_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        #1;
        if (ack_send)  begin n_send++; t_send = cyc; end
        if (ack_seen)  begin n_seen++; t_seen = cyc; end
        if (frame_err) begin n_ferr++; t_ferr = cyc; end
        if (rx_valid && !pv) begin n_vrise++; t_vrise = cyc; d_vrise = rx_data; end
        pv = rx_valid;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int per_of(input logic [1:0] code);
        if (code == 2'b01) return 4 * F;
        if (code == 2'b11) return F;
        return 2 * F;
    endfunction

    task automatic send_pkt(input logic [7:0] b, input bit is_ack, input logic stop_lvl,
                            output int c0);
        int p;
        p = per_of(speed_sel);
        @(negedge clk);
        c0 = cyc;
        rx_line = 1'b1;
        repeat (p) @(negedge clk);
        rx_line = !is_ack;
        repeat (p) @(negedge clk);
        if (!is_ack) begin
            for (int i = 0; i < 8; i++) begin
                rx_line = b[i];
                repeat (p) @(negedge clk);
            end
            rx_line = stop_lvl;
            repeat (p) @(negedge clk);
            if (stop_lvl) repeat (3 * p) @(negedge clk);
        end
        rx_line = 1'b0;
        repeat (2 * p) @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 valid in reset", int'(rx_valid), 0);
        chk("R1 strobes in reset", int'(ack_seen | ack_send | frame_err), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk("R1 valid after reset", int'(rx_valid), 0);
        chk("R1 strobes after reset", int'(ack_seen | ack_send | frame_err), 0);
    endtask

    task automatic t_speeds();
        int c0, p;
        logic [7:0] b;
        rx_ready = 1'b1;
        for (int sp = 0; sp < 4; sp++) begin
            speed_sel = 2'(sp);
            p = per_of(speed_sel);
            b = 8'(8'hA5 + sp * 37);
            send_pkt(b, 1'b0, 1'b0, c0);
            chk("R2 byte timing", t_vrise, c0 + 3 + p/2 + 10*p);
            chk("R3 byte value", int'(d_vrise), int'(b));
            chk("R5 early ack timing", t_send, c0 + 3 + p/2 + p);
        end
    endtask

    task automatic t_ack();
        int c0, ns, nv, nf;
        for (int k = 0; k < 2; k++) begin
            speed_sel = (k == 0) ? 2'b11 : 2'b01;
            ns = n_send; nv = n_vrise; nf = n_ferr;
            send_pkt(8'h00, 1'b1, 1'b0, c0);
            chk("R4 ack_seen timing", t_seen, c0 + 3 + per_of(speed_sel)/2 + per_of(speed_sel));
            chk("R4 no ack_send, byte or error", (n_send - ns) + (n_vrise - nv) + (n_ferr - nf), 0);
        end
    endtask

    task automatic t_defer();
        int c0, s0, c;
        speed_sel = 2'b10;
        rx_ready = 1'b0;
        s0 = n_send;
        send_pkt(8'h3C, 1'b0, 1'b0, c0);
        chk("R5 ack with space", t_send, c0 + 3 + 4 + 8);
        chk("R3 first byte", int'(d_vrise), 'h3C);
        send_pkt(8'hC3, 1'b0, 1'b0, c0);
        chk("R6 ack withheld", n_send, s0 + 1);
        chk("R7 held byte kept", int'(rx_data), 'h3C);
        chk("R7 valid kept", int'(rx_valid), 1);
        @(negedge clk);
        c = cyc;
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        #2;
        chk("R6 deferred ack timing", t_send, c + 1);
        chk("R6 deferred ack count", n_send, s0 + 2);
        chk("R6 parked byte presented", int'(rx_data), 'hC3);
        chk("R6 parked valid", int'(rx_valid), 1);
        @(negedge clk);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        #2;
        chk("R6 drained", int'(rx_valid), 0);
        chk("R6 no extra ack", n_send, s0 + 2);
        rx_ready = 1'b1;
    endtask

    task automatic t_frame();
        int c0, nv;
        speed_sel = 2'b10;
        nv = n_vrise;
        send_pkt(8'h81, 1'b0, 1'b1, c0);
        chk("R8 frame_err timing", t_ferr, c0 + 3 + 4 + 80);
        chk("R8 byte discarded", n_vrise, nv);
        send_pkt(8'h6E, 1'b0, 1'b0, c0);
        chk("R8 recovery timing", t_vrise, c0 + 3 + 4 + 80);
        chk("R8 recovery value", int'(d_vrise), 'h6E);
    endtask

    task automatic t_glitch();
        int c0, tot;
        speed_sel = 2'b10;
        tot = n_send + n_seen + n_ferr + n_vrise;
        @(negedge clk);
        rx_line = 1'b1;
        @(negedge clk);
        rx_line = 1'b0;
        repeat (12 * 8) @(negedge clk);
        chk("R9 glitch ignored", n_send + n_seen + n_ferr + n_vrise, tot);
        send_pkt(8'h17, 1'b0, 1'b0, c0);
        chk("R9 next packet timing", t_vrise, c0 + 3 + 4 + 80);
        chk("R9 next packet value", int'(d_vrise), 'h17);
    endtask

    initial begin
        t_reset();
        t_speeds();
        t_ack();
        t_defer();
        t_frame();
        t_glitch();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule